// File: doc/BRIEF.md
# Byte-Serial SPI Master with Register Interface

This block is a memory-mapped SPI master that moves one byte per transfer, full duplex. Software reaches it through six word registers: received data, transmit data, status, control, a reserved word and a slave-select mask. A byte written to the transmit register waits in a one-deep holding stage. It moves into the shift engine as soon as the engine is idle. While the byte goes out on MOSI, the byte arriving on MISO is gathered and placed in the receive register.

The status register has three flags. The first says the holding stage can take a byte. The second says a received byte is waiting. The third says the holding stage is empty and the shifter has stopped. Chip select is active low. Each line whose bit is set in the slave-select mask goes low while a byte is in flight. A forced-select bit in the control register keeps those lines low between bytes, so a multi-byte command stays framed until software clears the bit. The serial clock runs in mode 0, MSB first, at a fixed division of the system clock.

Top module: `spi_reg_master`

## Requirements
- R1: The register word addresses are 0 receive data, 1 transmit data, 2 status, 3 control, 4 reserved, 5 slave select. The reserved word and the transmit word read as 0. Writes to the reserved word and to the status word change nothing.
- R2: After reset, status reads 0x5 (bit 0 set, bit 1 clear, bit 2 set), control reads 0, slave select reads 1, every chip-select line is high and the serial clock is low.
- R3: Status bit 0 (transmit ready) clears on the clock edge that accepts a transmit-data write. It sets again on the next edge, when the byte moves into the shifter. A transmit-data write made while bit 0 is clear is ignored.
- R4: Status bit 1 (receive ready) sets when a byte completes. A read of the receive-data word clears it. A byte that completes before the previous one was read overwrites it.
- R5: Status bit 2 (transmitter empty) is set only when no byte is held and the shifter is idle. It stays clear from the accepting write until the last bit has shifted out.
- R6: Transfers use SPI mode 0 and send MSB first. The serial clock idles low. MOSI is stable at each rising edge. MISO is sampled on each rising edge. Each clock phase lasts CLK_DIV system clocks.
- R7: The receive-data word holds the byte that the slave drove on MISO during the transfer, MSB first.
- R8: Chip select is active low. During a transfer exactly the lines whose bit is 1 in the slave-select mask are low. All lines are high once the transmitter is empty and forced select is off.
- R9: Control bit 0 (forced select) holds the selected lines low while it is 1, whether the block is idle or between bytes. Clearing it releases them.
- R10: Writing 0 to status, 0 to control and 1 to slave select returns the block to idle with all lines high and slave 0 chosen for the next transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 3 | Register word address |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (read side effects) |
| bus_wdata | input | BUS_W | Write data |
| bus_rdata | output | BUS_W | Read data for bus_addr |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| ss_n | output | SS_W | Active-low chip selects |

## Verification
The bench targets the cycle in which transmit-ready drops and comes back. A design that hands the byte over late, or never, would leave the flag low or send nothing. It issues a second transmit write in the cycle right after the first; a design that accepts it would put an extra byte on the wire. The bench sends three bytes under forced select and counts every rise of any chip-select line during that window, which catches a design that lets go between bytes. It also skips reads during that sequence to check that the receive register keeps the last byte and not a stale or mixed one. Finally it runs the software reset write sequence after a forced select on a different mask, which exposes a design that keeps a line low or keeps the old slave chosen.

// File: rtl/spi_reg_pkg.sv
package spi_reg_pkg;
  typedef enum logic [2:0] {
    RA_RX   = 3'd0,
    RA_TX   = 3'd1,
    RA_STAT = 3'd2,
    RA_CTRL = 3'd3,
    RA_RSVD = 3'd4,
    RA_SSEL = 3'd5
  } reg_addr_e;

  localparam int unsigned ST_TRDY  = 0;
  localparam int unsigned ST_RRDY  = 1;
  localparam int unsigned ST_TMT   = 2;
  localparam int unsigned CTL_HOLD = 0;
endpackage

// File: rtl/spi_tick.sv
module spi_tick #(
  parameter int unsigned DIV = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic tick
);
  localparam int unsigned CW = (DIV > 1) ? $clog2(DIV) : 1;

  logic [CW-1:0] cnt_q, cnt_n;

  always_comb begin
    tick  = run && (cnt_q == CW'(DIV - 1));
    cnt_n = (!run || tick) ? '0 : cnt_q + CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_n;
  end
endmodule

// File: rtl/spi_shifter.sv
module spi_shifter #(
  parameter int unsigned DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [DW-1:0] ld_data,
  input  logic          tick,
  input  logic          miso,
  output logic          busy,
  output logic          sclk,
  output logic          mosi,
  output logic          done,
  output logic [DW-1:0] rx_byte
);
  localparam int unsigned BCW = $clog2(DW) + 1;

  logic          busy_q, busy_n;
  logic          sclk_q, sclk_n;
  logic [DW-1:0] sh_q, sh_n;
  logic          samp_q, samp_n;
  logic [BCW-1:0] bcnt_q, bcnt_n;

  always_comb begin
    busy_n  = busy_q;
    sclk_n  = sclk_q;
    sh_n    = sh_q;
    samp_n  = samp_q;
    bcnt_n  = bcnt_q;
    done    = 1'b0;
    rx_byte = {sh_q[DW-2:0], samp_q};
    if (!busy_q) begin
      if (load) begin
        busy_n = 1'b1;
        sclk_n = 1'b0;
        sh_n   = ld_data;
        bcnt_n = '0;
      end
    end else if (tick) begin
      if (!sclk_q) begin
        sclk_n = 1'b1;
        samp_n = miso;
      end else begin
        sclk_n = 1'b0;
        sh_n   = {sh_q[DW-2:0], samp_q};
        bcnt_n = bcnt_q + BCW'(1);
        if (bcnt_q == BCW'(DW - 1)) begin
          busy_n = 1'b0;
          done   = 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      sclk_q <= 1'b0;
      sh_q   <= '0;
      samp_q <= 1'b0;
      bcnt_q <= '0;
    end else begin
      busy_q <= busy_n;
      sclk_q <= sclk_n;
      sh_q   <= sh_n;
      samp_q <= samp_n;
      bcnt_q <= bcnt_n;
    end
  end

  assign busy = busy_q;
  assign sclk = sclk_q;
  assign mosi = busy_q & sh_q[DW-1];
endmodule

// File: rtl/spi_regfile.sv
module spi_regfile
  import spi_reg_pkg::*;
#(
  parameter int unsigned DW = 8,
  parameter int unsigned SW = 4,
  parameter int unsigned BW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [2:0]    addr,
  input  logic          wr,
  input  logic          rd,
  input  logic [BW-1:0] wdata,
  output logic [BW-1:0] rdata,
  input  logic          busy,
  input  logic          done,
  input  logic [DW-1:0] rx_byte,
  output logic          load,
  output logic [DW-1:0] ld_data,
  output logic          hold_sel,
  output logic [SW-1:0] sel,
  output logic          trdy,
  output logic          rrdy,
  output logic          tmt
);
  logic [DW-1:0] tx_buf_q, tx_buf_n;
  logic          full_q, full_n;
  logic [DW-1:0] rx_q, rx_n;
  logic          rrdy_q, rrdy_n;
  logic          hold_q, hold_n;
  logic [SW-1:0] sel_q, sel_n;
  logic          wr_tx, unused_wbits;

  assign unused_wbits = ^wdata;

  always_comb begin
    wr_tx    = wr && (addr == RA_TX) && !full_q;
    load     = full_q && !busy;
    tx_buf_n = wr_tx ? wdata[DW-1:0] : tx_buf_q;
    full_n   = full_q;
    if (load)  full_n = 1'b0;
    if (wr_tx) full_n = 1'b1;
    rx_n   = done ? rx_byte : rx_q;
    rrdy_n = rrdy_q;
    if (rd && (addr == RA_RX)) rrdy_n = 1'b0;
    if (done)                  rrdy_n = 1'b1;
    hold_n = (wr && (addr == RA_CTRL)) ? wdata[CTL_HOLD] : hold_q;
    sel_n  = (wr && (addr == RA_SSEL)) ? wdata[SW-1:0] : sel_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_buf_q <= '0;
      full_q   <= 1'b0;
      rx_q     <= '0;
      rrdy_q   <= 1'b0;
      hold_q   <= 1'b0;
      sel_q    <= SW'(1);
    end else begin
      tx_buf_q <= tx_buf_n;
      full_q   <= full_n;
      rx_q     <= rx_n;
      rrdy_q   <= rrdy_n;
      hold_q   <= hold_n;
      sel_q    <= sel_n;
    end
  end

  always_comb begin
    trdy = !full_q;
    rrdy = rrdy_q;
    tmt  = !full_q && !busy;
    rdata = '0;
    case (addr)
      RA_RX: rdata = BW'(rx_q);
      RA_STAT: begin
        rdata[ST_TRDY] = trdy;
        rdata[ST_RRDY] = rrdy;
        rdata[ST_TMT]  = tmt;
      end
      RA_CTRL: rdata = BW'(hold_q);
      RA_SSEL: rdata = BW'(sel_q);
      default: rdata = '0;
    endcase
  end

  assign ld_data  = tx_buf_q;
  assign hold_sel = hold_q;
  assign sel      = sel_q;
endmodule

// File: rtl/spi_reg_master.sv
module spi_reg_master #(
  parameter int unsigned DATA_W  = 8,
  parameter int unsigned SS_W    = 4,
  parameter int unsigned CLK_DIV = 2,
  parameter int unsigned BUS_W   = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [2:0]       bus_addr,
  input  logic             bus_wr,
  input  logic             bus_rd,
  input  logic [BUS_W-1:0] bus_wdata,
  output logic [BUS_W-1:0] bus_rdata,
  output logic             sclk,
  output logic             mosi,
  input  logic             miso,
  output logic [SS_W-1:0]  ss_n
);
  logic [1:0]        rst_sync_q;
  logic              rst_n_s;
  logic              busy_w, done_w, tick_w, load_w, hold_w;
  logic              trdy_w, rrdy_w, tmt_w;
  logic [DATA_W-1:0] rx_byte_w, ld_data_w;
  logic [SS_W-1:0]   sel_w;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_s = rst_sync_q[1];

  spi_tick #(.DIV(CLK_DIV)) u_tick (
    .clk(clk), .rst_n(rst_n_s), .run(busy_w), .tick(tick_w)
  );

  spi_shifter #(.DW(DATA_W)) u_shift (
    .clk(clk), .rst_n(rst_n_s), .load(load_w), .ld_data(ld_data_w),
    .tick(tick_w), .miso(miso), .busy(busy_w), .sclk(sclk), .mosi(mosi),
    .done(done_w), .rx_byte(rx_byte_w)
  );

  spi_regfile #(.DW(DATA_W), .SW(SS_W), .BW(BUS_W)) u_regs (
    .clk(clk), .rst_n(rst_n_s), .addr(bus_addr), .wr(bus_wr), .rd(bus_rd),
    .wdata(bus_wdata), .rdata(bus_rdata), .busy(busy_w), .done(done_w),
    .rx_byte(rx_byte_w), .load(load_w), .ld_data(ld_data_w),
    .hold_sel(hold_w), .sel(sel_w), .trdy(trdy_w), .rrdy(rrdy_w), .tmt(tmt_w)
  );

  assign ss_n = ~(sel_w & {SS_W{hold_w | busy_w}});
endmodule

// File: rtl/spi_reg_master_chk.sv
module spi_reg_master_chk #(
  parameter int unsigned SS_W = 4
) (
  input logic            clk,
  input logic            rst_n_s,
  input logic [2:0]      bus_addr,
  input logic            bus_wr,
  input logic            bus_rd,
  input logic            sclk,
  input logic [SS_W-1:0] ss_n,
  input logic [SS_W-1:0] sel,
  input logic            hold_sel,
  input logic            trdy,
  input logic            rrdy,
  input logic            tmt,
  input logic            done
);
  assert_only_selected_R8: assert property (@(posedge clk) disable iff (!rst_n_s)
    ((~ss_n) & (~sel)) == '0);

  assert_sclk_idle_low_R6: assert property (@(posedge clk) disable iff (!rst_n_s)
    (&ss_n) |-> !sclk);

  assert_release_when_empty_R5: assert property (@(posedge clk) disable iff (!rst_n_s)
    (tmt && !hold_sel) |-> (&ss_n));

  assert_trdy_drop_R3: assert property (@(posedge clk) disable iff (!rst_n_s)
    (bus_wr && bus_addr == 3'd1 && trdy) |=> !trdy);

  assert_rrdy_clear_R4: assert property (@(posedge clk) disable iff (!rst_n_s)
    (bus_rd && bus_addr == 3'd0 && !done) |=> !rrdy);

  assert_rrdy_set_R4: assert property (@(posedge clk) disable iff (!rst_n_s)
    done |=> rrdy);

  assert_hold_steady_R9: assert property (@(posedge clk) disable iff (!rst_n_s)
    (hold_sel && $past(hold_sel) && $stable(sel)) |-> $stable(ss_n));
endmodule

bind spi_reg_master spi_reg_master_chk #(.SS_W(SS_W)) u_chk (
  .clk(clk), .rst_n_s(rst_n_s), .bus_addr(bus_addr), .bus_wr(bus_wr),
  .bus_rd(bus_rd), .sclk(sclk), .ss_n(ss_n), .sel(sel_w), .hold_sel(hold_w),
  .trdy(trdy_w), .rrdy(rrdy_w), .tmt(tmt_w), .done(done_w)
);

// File: tb/spi_reg_master_test.sv
module spi_reg_master_test;
  localparam int CLK_PERIOD = 10;
  localparam int DIV = 2;

  logic        clk, rst_n, bus_wr, bus_rd, sclk, mosi, miso;
  logic [2:0]  bus_addr;
  logic [15:0] bus_wdata, bus_rdata;
  logic [3:0]  ss_n;

  int checks = 0, failures = 0;
  logic [7:0] exp_mosi_q[$];
  logic [7:0] miso_q[$];
  int   sent_bytes = 0, s_cnt = 0, ss_rises = 0;
  logic [7:0] m_sh, s_sh;
  logic s_loaded = 1'b0;
  time  last_rise = 0;
  logic [15:0] rd_v;

  spi_reg_master #(.DATA_W(8), .SS_W(4), .CLK_DIV(DIV), .BUS_W(16)) uut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .sclk(sclk), .mosi(mosi), .miso(miso), .ss_n(ss_n)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  assign miso = s_sh[7];

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // slave model and monitor side of the scoreboard
  always @(posedge sclk) begin
    if (s_cnt != 0)
      check("R6 sclk period", 32'(($time - last_rise) / CLK_PERIOD), 32'(2 * DIV));
    last_rise = $time;
    if (s_cnt == 0) s_loaded = 1'b0;
    m_sh = {m_sh[6:0], mosi};
    s_cnt++;
    if (s_cnt == 8) begin
      s_cnt = 0;
      sent_bytes++;
      if (exp_mosi_q.size() == 0) check("R3 unexpected mosi byte", 32'(m_sh), 32'hFFFF);
      else check("R6 mosi byte msb first", 32'(m_sh), 32'(exp_mosi_q.pop_front()));
      if (miso_q.size() != 0) begin
        s_sh = miso_q.pop_front();
        s_loaded = 1'b1;
      end
    end
  end

  always @(negedge sclk) if (s_cnt != 0) s_sh = {s_sh[6:0], 1'b0};

  always @(posedge ss_n[0] or posedge ss_n[1] or posedge ss_n[2] or posedge ss_n[3])
    if (rst_n) ss_rises++;

  // driver side: push expected items, then queue slave data
  task automatic expect_byte(input logic [7:0] tx, input logic [7:0] rx);
    exp_mosi_q.push_back(tx);
    miso_q.push_back(rx);
    if (!s_loaded && s_cnt == 0) begin
      s_sh = miso_q.pop_front();
      s_loaded = 1'b1;
    end
  endtask

  // all bus tasks start and end at a falling clock edge
  task automatic bus_write(input logic [2:0] a, input logic [15:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [2:0] a, output logic [15:0] d);
    bus_addr = a; bus_rd = 1'b1;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic peek(input logic [2:0] a, output logic [15:0] d);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic wait_bit(input int b);
    logic [15:0] s;
    for (int i = 0; i < 2000; i++) begin
      peek(3'd2, s);
      if (s[b]) break;
      @(negedge clk);
    end
    @(negedge clk);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    rst_n = 1'b0; bus_wr = 1'b0; bus_rd = 1'b0; bus_addr = '0; bus_wdata = '0;
    s_sh = 8'h00; m_sh = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R2 reset state
    peek(3'd2, rd_v); check("R2 status", 32'(rd_v), 32'h5);
    peek(3'd3, rd_v); check("R2 control", 32'(rd_v), 32'h0);
    peek(3'd5, rd_v); check("R2 slave select", 32'(rd_v), 32'h1);
    check("R2 ss_n", 32'(ss_n), 32'hF);
    check("R2 sclk", 32'(sclk), 32'h0);

    // R1 reserved and status writes ignored
    bus_write(3'd4, 16'hFFFF);
    bus_write(3'd2, 16'hFFFF);
    peek(3'd4, rd_v); check("R1 reserved reads zero", 32'(rd_v), 32'h0);
    peek(3'd2, rd_v); check("R1 status write ignored", 32'(rd_v), 32'h5);

    // single byte, slave 2
    bus_write(3'd5, 16'h0004);
    expect_byte(8'hA5, 8'h3C);
    bus_write(3'd1, 16'h00A5);
    peek(3'd2, rd_v); check("R3 trdy cleared after write", 32'(rd_v[0]), 32'h0);
    check("R5 tmt cleared after write", 32'(rd_v[2]), 32'h0);
    @(negedge clk);
    peek(3'd2, rd_v); check("R3 trdy back after load", 32'(rd_v[0]), 32'h1);
    check("R5 tmt clear while shifting", 32'(rd_v[2]), 32'h0);
    check("R8 only selected line low", 32'(ss_n), 32'hB);
    wait_bit(2);
    check("R8 released after empty", 32'(ss_n), 32'hF);
    peek(3'd2, rd_v); check("R4 rrdy set", 32'(rd_v[1]), 32'h1);
    bus_read(3'd0, rd_v); check("R7 received byte", 32'(rd_v), 32'h3C);
    peek(3'd2, rd_v); check("R4 rrdy cleared by read", 32'(rd_v[1]), 32'h0);

    // R3 write while not ready is dropped
    expect_byte(8'h81, 8'h7E);
    bus_write(3'd1, 16'h0081);
    bus_write(3'd1, 16'h0055);
    wait_bit(2);
    repeat (4) @(negedge clk);
    check("R3 only one byte sent", 32'(sent_bytes), 32'd2);
    bus_read(3'd0, rd_v); check("R7 second received byte", 32'(rd_v), 32'h7E);

    // R9 forced select across three bytes, R4 overwrite
    bus_write(3'd3, 16'h0001);
    check("R9 hold asserts while idle", 32'(ss_n), 32'hB);
    ss_rises = 0;
    expect_byte(8'h12, 8'hF0);
    expect_byte(8'h34, 8'h0F);
    expect_byte(8'hC3, 8'h99);
    wait_bit(0); bus_write(3'd1, 16'h0012);
    wait_bit(0); bus_write(3'd1, 16'h0034);
    wait_bit(0); bus_write(3'd1, 16'h00C3);
    wait_bit(2);
    check("R9 no release between bytes", 32'(ss_rises), 32'd0);
    check("R9 still low after last byte", 32'(ss_n), 32'hB);
    bus_read(3'd0, rd_v); check("R4 newest byte kept", 32'(rd_v), 32'h99);
    bus_write(3'd3, 16'h0000);
    check("R9 clear releases", 32'(ss_n), 32'hF);

    // R10 software re-init sequence
    bus_write(3'd5, 16'h0006);
    bus_write(3'd3, 16'h0001);
    check("R10 hold on mask 6", 32'(ss_n), 32'h9);
    bus_write(3'd2, 16'h0000);
    bus_write(3'd3, 16'h0000);
    bus_write(3'd5, 16'h0001);
    check("R10 all released", 32'(ss_n), 32'hF);
    peek(3'd2, rd_v); check("R10 idle status", 32'(rd_v), 32'h5);
    expect_byte(8'h5A, 8'hA5);
    bus_write(3'd1, 16'h005A);
    @(negedge clk);
    check("R10 slave 0 chosen", 32'(ss_n), 32'hE);
    wait_bit(1);
    bus_read(3'd0, rd_v); check("R7 final received byte", 32'(rd_v), 32'hA5);

    repeat (4) @(negedge clk);
    check("R6 all expected bytes seen", 32'(exp_mosi_q.size()), 32'd0);
    check("R6 total bytes", 32'(sent_bytes), 32'd6);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule